// File: doc/BRIEF.md
# Frame Buffer Address Queue

This block supplies the base address that a capture DMA writer uses for each incoming image frame. Software pushes buffer base addresses into a small queue ahead of time. When a frame-start pulse arrives, the block moves the oldest queued address into the active-frame register. The DMA writer then uses that register for the whole frame. Because the handover happens only at frame start, any later push or static-address change reaches the following frame and never the one already in progress.

When queue mode is off, every frame takes the single static address input and the queue is left alone. When queue mode is on, the block raises three interrupts:

- A low-water level while the queue holds fewer entries than a programmed threshold.
- A one-cycle pulse when the stored-frame counter reaches its threshold.
- A one-cycle pulse when a frame starts with nothing queued.

A frame that starts with an empty queue is not captured. Its active address is marked invalid, and its frame-written pulse does not count.

Top module: `fbuf_addr_queue`

## Requirements
- R1: In queue mode, a frame start with a non-empty queue puts the oldest queued address on active_addr and drives active_valid high from the next cycle, and removes that entry.
- R2: active_addr and active_valid change only in the cycle after a frame start. Pushes and static_addr changes made at any other time leave them unchanged until the next frame start.
- R3: fill_level equals accepted pushes minus entries removed. A push and a removal in the same cycle leave it unchanged, and it never exceeds DEPTH.
- R4: A push while fill_level equals DEPTH is dropped, is never handed out, and sets push_overflow. push_overflow stays high until reset.
- R5: In queue mode, a frame start with fill_level 0 drives active_valid low and irq_lost high for exactly the next cycle. A push in that same cycle is queued, but it does not serve that frame.
- R6: irq_low_water is high exactly when queue mode is on and fill_level is below low_water_thr.
- R7: stored_count increments by one for each frame_written pulse seen while active_valid is high. It ignores frame_written while active_valid is low, and it holds at its all-ones value.
- R8: irq_stored is a one-cycle pulse in the cycle after stored_count increments to a value equal to stored_thr. It is raised only in queue mode.
- R9: cnt_clear sets stored_count to 0 in the next cycle, taking priority over an increment in the same cycle. It also drives cnt_cleared high for exactly that one cycle.
- R10: With queue mode off, a frame start loads static_addr into active_addr with active_valid high. The queue is not consumed, and irq_lost, irq_stored and irq_low_water stay low.
- R11: After reset, active_valid, fill_level, stored_count, push_overflow and all interrupt and event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode_en | input | 1 | 1 selects queue mode, 0 selects the static address |
| static_addr | input | ADDR_W | Address used for every frame when queue mode is off |
| push_valid | input | 1 | Software push strobe |
| push_addr | input | ADDR_W | Address pushed with push_valid |
| frame_start | input | 1 | One-cycle frame start (vertical sync) pulse |
| frame_written | input | 1 | One-cycle pulse when the current frame is fully written |
| cnt_clear | input | 1 | One-cycle stored-frame counter clear strobe |
| low_water_thr | input | LVL_W | Low-water threshold on fill_level |
| stored_thr | input | CNT_W | Stored-frame interrupt threshold |
| active_addr | output | ADDR_W | Base address for the frame in progress |
| active_valid | output | 1 | The frame in progress has a valid address |
| fill_level | output | LVL_W | Number of queued addresses |
| stored_count | output | CNT_W | Stored-frame counter |
| push_overflow | output | 1 | Sticky flag for a dropped push |
| irq_low_water | output | 1 | Queue below threshold (level) |
| irq_stored | output | 1 | Stored-frame threshold reached (pulse) |
| irq_lost | output | 1 | Frame started with an empty queue (pulse) |
| cnt_cleared | output | 1 | Counter-cleared event (pulse) |

## Verification
The bench builds the block with DEPTH 4, ADDR_W 16 and CNT_W 4. A shallow queue fills in four pushes, so dropped pushes and a push landing together with a removal at full level happen often in the random phase. The 4-bit counter reaches its all-ones hold value after fifteen written frames, so counter saturation and a threshold at the top value are tested. Long mode-toggling random traffic also produces frame starts on an empty queue that coincide with pushes.

// File: rtl/fbq_pkg.sv
package fbq_pkg;
    localparam int unsigned FBQ_ADDR_W = 32;
    localparam int unsigned FBQ_DEPTH  = 8;
    localparam int unsigned FBQ_CNT_W  = 8;

    // one-cycle events raised by the stored-frame counter
    typedef struct packed {
        logic reached;
        logic cleared;
    } fbq_cnt_evt_t;
endpackage

// File: rtl/fbq_store.sv
module fbq_store #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [LVL_W-1:0]  level,
    output logic              overflow
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [LVL_W-1:0]             lvl;
        logic                         ovf;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    logic take, give;

    always_comb begin
        st_d = st_q;
        take = push_valid && (st_q.lvl != FULL_LVL);
        give = pop && (st_q.lvl != '0);
        if (take) begin
            st_d.mem[st_q.wr] = push_addr;
            st_d.wr           = ptr_next(st_q.wr);
        end
        if (give) begin
            st_d.rd = ptr_next(st_q.rd);
        end
        if (push_valid && !take) begin
            st_d.ovf = 1'b1;
        end
        unique case ({take, give})
            2'b10:   st_d.lvl = st_q.lvl + 1'b1;
            2'b01:   st_d.lvl = st_q.lvl - 1'b1;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_addr = st_q.mem[st_q.rd];
    assign level     = st_q.lvl;
    assign overflow  = st_q.ovf;
endmodule

// File: rtl/fbq_frame.sv
module fbq_frame #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] static_addr,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [LVL_W-1:0]  level,
    output logic              pop,
    output logic [ADDR_W-1:0] active_addr,
    output logic              active_valid,
    output logic              lost
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
        logic              lost;
    } frame_t;

    frame_t fr_d, fr_q;
    logic   have_entry;

    always_comb begin
        fr_d       = fr_q;
        fr_d.lost  = 1'b0;
        have_entry = (level != '0);
        pop        = fifo_mode && frame_start && have_entry;
        if (frame_start) begin
            if (!fifo_mode) begin
                fr_d.addr  = static_addr;
                fr_d.valid = 1'b1;
            end else if (have_entry) begin
                fr_d.addr  = head_addr;
                fr_d.valid = 1'b1;
            end else begin
                fr_d.valid = 1'b0;
                fr_d.lost  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign active_addr  = fr_q.addr;
    assign active_valid = fr_q.valid;
    assign lost         = fr_q.lost;
endmodule

// File: rtl/fbq_count.sv
module fbq_count
    import fbq_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic             frame_written,
    input  logic             active_valid,
    input  logic             clear,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] count,
    output fbq_cnt_evt_t     evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        fbq_cnt_evt_t     ev;
    } cnt_t;

    cnt_t ct_d, ct_q;
    logic bump;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        ct_d       = ct_q;
        bump       = frame_written && active_valid && (ct_q.cnt != CNT_MAX);
        cnt_inc    = ct_q.cnt + 1'b1;
        ct_d.ev    = '0;
        if (clear) begin
            ct_d.cnt        = '0;
            ct_d.ev.cleared = 1'b1;
        end else if (bump) begin
            ct_d.cnt        = cnt_inc;
            ct_d.ev.reached = fifo_mode && (cnt_inc == thr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign count = ct_q.cnt;
    assign evt   = ct_q.ev;
endmodule

// File: rtl/fbuf_addr_queue.sv
module fbuf_addr_queue
    import fbq_pkg::*;
#(
    parameter int unsigned ADDR_W = FBQ_ADDR_W,
    parameter int unsigned DEPTH  = FBQ_DEPTH,
    parameter int unsigned CNT_W  = FBQ_CNT_W,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode_en,
    input  logic [ADDR_W-1:0] static_addr,
    input  logic              push_valid,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              frame_start,
    input  logic              frame_written,
    input  logic              cnt_clear,
    input  logic [LVL_W-1:0]  low_water_thr,
    input  logic [CNT_W-1:0]  stored_thr,
    output logic [ADDR_W-1:0] active_addr,
    output logic              active_valid,
    output logic [LVL_W-1:0]  fill_level,
    output logic [CNT_W-1:0]  stored_count,
    output logic              push_overflow,
    output logic              irq_low_water,
    output logic              irq_stored,
    output logic              irq_lost,
    output logic              cnt_cleared
);
    logic              pop;
    logic [ADDR_W-1:0] head_addr;
    fbq_cnt_evt_t      cnt_evt;

    fbq_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_addr  (push_addr),
        .pop        (pop),
        .head_addr  (head_addr),
        .level      (fill_level),
        .overflow   (push_overflow)
    );

    fbq_frame #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_mode    (fifo_mode_en),
        .frame_start  (frame_start),
        .static_addr  (static_addr),
        .head_addr    (head_addr),
        .level        (fill_level),
        .pop          (pop),
        .active_addr  (active_addr),
        .active_valid (active_valid),
        .lost         (irq_lost)
    );

    fbq_count #(.CNT_W(CNT_W)) u_count (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_mode     (fifo_mode_en),
        .frame_written (frame_written),
        .active_valid  (active_valid),
        .clear         (cnt_clear),
        .thr           (stored_thr),
        .count         (stored_count),
        .evt           (cnt_evt)
    );

    assign irq_stored    = cnt_evt.reached;
    assign cnt_cleared   = cnt_evt.cleared;
    assign irq_low_water = fifo_mode_en && (fill_level < low_water_thr);
endmodule

// File: rtl/fbq_checks.sv
module fbq_checks #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned LVL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_mode_en,
    input logic              push_valid,
    input logic              frame_start,
    input logic              cnt_clear,
    input logic [ADDR_W-1:0] active_addr,
    input logic              active_valid,
    input logic [LVL_W-1:0]  fill_level,
    input logic [CNT_W-1:0]  stored_count,
    input logic              push_overflow,
    input logic              irq_low_water,
    input logic              irq_stored,
    input logic              irq_lost,
    input logic              cnt_cleared
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(active_addr) && $stable(active_valid)));

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !frame_start && fill_level == LVL_W'(DEPTH))
        |=> (push_overflow && fill_level == LVL_W'(DEPTH)));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_overflow |=> push_overflow);

    assert_lost_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lost |-> !active_valid);

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (cnt_cleared && stored_count == '0));

    assert_stored_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_cleared |-> !irq_stored);

    assert_static_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode_en |-> !irq_low_water);
endmodule

bind fbuf_addr_queue fbq_checks #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_mode_en  (fifo_mode_en),
    .push_valid    (push_valid),
    .frame_start   (frame_start),
    .cnt_clear     (cnt_clear),
    .active_addr   (active_addr),
    .active_valid  (active_valid),
    .fill_level    (fill_level),
    .stored_count  (stored_count),
    .push_overflow (push_overflow),
    .irq_low_water (irq_low_water),
    .irq_stored    (irq_stored),
    .irq_lost      (irq_lost),
    .cnt_cleared   (cnt_cleared)
);

// File: tb/sim_fbuf_addr_queue.sv
`timescale 1ns/1ps
module sim_fbuf_addr_queue;
    localparam int unsigned AW = 16;
    localparam int unsigned DP = 4;
    localparam int unsigned CW = 4;
    localparam int unsigned LW = $clog2(DP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_mode_en = 1'b0;
    logic [AW-1:0] static_addr = '0;
    logic          push_valid = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic          frame_start = 1'b0;
    logic          frame_written = 1'b0;
    logic          cnt_clear = 1'b0;
    logic [LW-1:0] low_water_thr = '0;
    logic [CW-1:0] stored_thr = '0;
    logic [AW-1:0] active_addr;
    logic          active_valid;
    logic [LW-1:0] fill_level;
    logic [CW-1:0] stored_count;
    logic          push_overflow, irq_low_water, irq_stored, irq_lost, cnt_cleared;

    fbuf_addr_queue #(.ADDR_W(AW), .DEPTH(DP), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_mode_en(fifo_mode_en), .static_addr(static_addr),
        .push_valid(push_valid), .push_addr(push_addr), .frame_start(frame_start),
        .frame_written(frame_written), .cnt_clear(cnt_clear), .low_water_thr(low_water_thr),
        .stored_thr(stored_thr), .active_addr(active_addr), .active_valid(active_valid),
        .fill_level(fill_level), .stored_count(stored_count), .push_overflow(push_overflow),
        .irq_low_water(irq_low_water), .irq_stored(irq_stored), .irq_lost(irq_lost),
        .cnt_cleared(cnt_cleared)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int n_cyc = 0;
    bit chk_on = 1'b0;

    // behavioural reference state
    logic [AW-1:0] mq[$];
    logic [AW-1:0] m_addr;
    logic          m_valid, m_ovf, m_st, m_lost, m_clr;
    int            m_cnt;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, n_cyc);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin : model
        int            osz;
        logic [AW-1:0] hd;
        bit            inc;
        if (!rst_n) begin
            mq.delete();
            m_addr = '0; m_valid = 0; m_ovf = 0; m_st = 0; m_lost = 0; m_clr = 0; m_cnt = 0;
        end else begin
            osz = mq.size();
            hd  = (osz > 0) ? mq[0] : '0;
            inc = frame_written && m_valid && (m_cnt != 15);
            m_lost = fifo_mode_en && frame_start && (osz == 0);
            if (fifo_mode_en && frame_start && osz > 0) void'(mq.pop_front());
            if (push_valid) begin
                if (osz < DP) mq.push_back(push_addr);
                else m_ovf = 1'b1;
            end
            if (frame_start) begin
                if (!fifo_mode_en) begin m_addr = static_addr; m_valid = 1'b1; end
                else if (osz > 0) begin m_addr = hd; m_valid = 1'b1; end
                else m_valid = 1'b0;
            end
            m_st  = 1'b0;
            m_clr = cnt_clear;
            if (cnt_clear) m_cnt = 0;
            else if (inc) begin
                m_cnt = m_cnt + 1;
                m_st  = fifo_mode_en && (m_cnt == int'(stored_thr));
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            check(active_valid === m_valid, "R1 R5 active_valid", active_valid, m_valid);
            if (m_valid)
                check(active_addr === m_addr, "R1 R2 R10 active_addr", active_addr, m_addr);
            check(int'(fill_level) == mq.size(), "R3 fill_level", fill_level, mq.size());
            check(push_overflow === m_ovf, "R4 push_overflow", push_overflow, m_ovf);
            check(irq_lost === m_lost, "R5 irq_lost", irq_lost, m_lost);
            check(irq_low_water === (fifo_mode_en && mq.size() < int'(low_water_thr)),
                  "R6 irq_low_water", irq_low_water, fifo_mode_en && mq.size() < int'(low_water_thr));
            check(int'(stored_count) == m_cnt, "R7 stored_count", stored_count, m_cnt);
            check(irq_stored === m_st, "R8 irq_stored", irq_stored, m_st);
            check(cnt_cleared === m_clr, "R9 cnt_cleared", cnt_cleared, m_clr);
        end
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000) begin
            n_bad++;
            $display("FAIL all: watchdog expired, actual %0d expected below 150000", n_cyc);
            summary();
        end
    end

    task automatic drive(input bit p, input logic [AW-1:0] a, input bit fs, input bit fw, input bit cl);
        @(negedge clk); #1;
        push_valid = p; push_addr = a; frame_start = fs; frame_written = fw; cnt_clear = cl;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, '0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset values
        check(active_valid === 1'b0, "R11 active_valid", active_valid, 0);
        check(fill_level === '0, "R11 fill_level", fill_level, 0);
        check(stored_count === '0, "R11 stored_count", stored_count, 0);
        check(push_overflow === 1'b0, "R11 push_overflow", push_overflow, 0);
        check({irq_stored, irq_lost, cnt_cleared} === 3'b000, "R11 events",
              {irq_stored, irq_lost, cnt_cleared}, 0);
        #1 rst_n = 1'b1;
        chk_on = 1'b1;

        // R1 R6: queue mode, two pushes, then a frame start
        fifo_mode_en = 1'b1; low_water_thr = 3'd2; stored_thr = 4'd3;
        drive(1, 16'h1000, 0, 0, 0);
        drive(1, 16'h2000, 0, 0, 0);
        drive(0, '0, 1, 0, 0);
        // R2: push after frame start does not touch active
        drive(1, 16'h3000, 0, 0, 0);
        drive(1, 16'h4000, 0, 1, 0);
        drive(1, 16'h5000, 0, 1, 0);
        // R4: full queue, extra push dropped; R3 push together with pop at full
        drive(1, 16'h6000, 0, 1, 0);
        drive(1, 16'h7000, 1, 0, 0);
        idle(2);
        for (int i = 0; i < 5; i++) begin
            drive(0, '0, 1, 1, 0);
            idle(1);
        end
        // R5: empty queue frame start with simultaneous push; written ignored
        drive(1, 16'h8000, 1, 0, 0);
        drive(0, '0, 0, 1, 0);
        drive(0, '0, 1, 0, 0);
        drive(0, '0, 0, 1, 0);
        // R9: clear together with written
        drive(0, '0, 0, 1, 1);
        idle(2);
        // R10: static mode, change static after frame start
        fifo_mode_en = 1'b0; static_addr = 16'hA5A0;
        drive(1, 16'h9000, 1, 0, 0);
        static_addr = 16'h5A50;
        drive(0, '0, 0, 1, 0);
        idle(2);
        drive(0, '0, 1, 1, 0);
        // R7 saturation in static mode
        for (int i = 0; i < 20; i++) drive(0, '0, 0, 1, 0);
        // R8 at the top value in queue mode
        drive(0, '0, 0, 0, 1);
        fifo_mode_en = 1'b1; stored_thr = 4'd15;
        drive(1, 16'h0100, 1, 0, 0);
        for (int i = 0; i < 17; i++) drive(0, '0, 0, 1, 0);
        idle(2);

        // random traffic
        void'($urandom(7));
        for (int i = 0; i < 4000; i++) begin
            if (i % 400 == 0) begin
                fifo_mode_en  = (i % 800) == 0;
                low_water_thr = LW'($urandom % (DP + 2));
                stored_thr    = CW'($urandom);
            end
            if ($urandom % 5 == 0) static_addr = AW'($urandom);
            drive(($urandom % 3) == 0, AW'($urandom), ($urandom % 6) == 0,
                  ($urandom % 3) == 0, ($urandom % 40) == 0);
        end
        idle(3);
        summary();
    end
endmodule